// File: doc/BRIEF.md
# Serial Register Write Loader

This block is a receive-only serial target. It feeds a register file: an external controller writes configuration registers over a three-wire serial link with an active-low select, a serial clock and one data line from controller to target. Nothing is driven back to the controller. The block has no read path and no output on the serial side.

The three serial inputs are first brought into the system clock domain. While select is low, each rising edge of the serial clock shifts one data bit, most significant bit first, into a 32-bit window that moves along with every bit. When select returns high, the window holds the 32 bits that arrived last. The block then produces a single register write. The older half of the window is the register address and the newer half is the value. A frame shorter than 32 bits produces no write. A longer frame keeps only its last 32 bits. The write is not started by a bit count. Only the end of the frame starts it.

Top module: `spi_reg_loader`

## Requirements
- R1: After reset, wr_en is low and wr_addr and wr_data are zero.
- R2: While spi_ss_n is low, each rising edge of spi_sclk samples spi_mosi. When a frame of exactly 32 bits ends, the write carries the first 16 bits as wr_addr and the last 16 bits as wr_data, each with its first bit received in bit 15.
- R3: wr_en is high for exactly one clk cycle. It goes high on the (SYNC_STAGES+1)-th rising edge of clk after spi_ss_n goes high, which is the third edge with the default of two stages.
- R4: A frame of more than 32 bits writes using only its last 32 bits, split as in R2.
- R5: A frame of fewer than 32 bits produces no write.
- R6: Each falling edge of spi_ss_n discards all bits received before it, so a short frame that follows a full frame still produces no write.
- R7: spi_sclk and spi_mosi activity while spi_ss_n is high produces no write and does not change the register outputs.
- R8: wr_en never rises while spi_ss_n is held low, however many bits arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_ss_n | input | 1 | Active-low frame select from the controller |
| spi_sclk | input | 1 | Serial clock; data sampled on its rising edge |
| spi_mosi | input | 1 | Serial data from the controller, MSB first |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 16 | Register address of the write |
| wr_data | output | 16 | Register value of the write |

## Verification
The hardest condition to reach from the ports is a stale bit count. Bits left over from an earlier full frame must not qualify a later short frame. The stimulus therefore sends a 31-bit frame straight after a 40-bit frame, and the window would then still hold valid-looking data. Trimming is exercised by a 40-bit frame whose first eight bits differ from its last 32. Serial clock bursts are sent while select is idle. A cycle-accurate model in the bench predicts the strobe cycle from the select edge and the synchronizer depth, and the bench compares the outputs with it on every clock.

// File: rtl/spi_loader_pkg.sv
package spi_loader_pkg;
  localparam int unsigned REG_ADDR_W = 16;
  localparam int unsigned REG_DATA_W = 16;
  localparam int unsigned FRAME_W    = REG_ADDR_W + REG_DATA_W;
  localparam int unsigned CNT_W      = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [REG_ADDR_W-1:0] addr;
    logic [REG_DATA_W-1:0] data;
  } reg_write_t;

  // Older half of the window is the address, newer half the value.
  function automatic reg_write_t split_frame(input logic [FRAME_W-1:0] win);
    reg_write_t w;
    w.addr = win[FRAME_W-1 -: REG_ADDR_W];
    w.data = win[REG_DATA_W-1:0];
    return w;
  endfunction

  // Bit counter that stops once a whole frame has been seen.
  function automatic logic [CNT_W-1:0] bump_count(input logic [CNT_W-1:0] cnt);
    if (cnt >= CNT_W'(FRAME_W)) return CNT_W'(FRAME_W);
    return cnt + CNT_W'(1);
  endfunction
endpackage

// File: rtl/sync_bits.sv
module sync_bits #(
  parameter int unsigned WIDTH     = 1,
  parameter int unsigned STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) chain[i] <= RESET_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/serial_capture.sv
module serial_capture
  import spi_loader_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s_ss_n,
  input  logic               s_sclk,
  input  logic               s_mosi,
  output logic               frame_end,
  output logic               frame_full,
  output logic [FRAME_W-1:0] frame_bits
);
  logic             ss_prev, sclk_prev;
  logic             ss_fall, sclk_rise;
  logic [FRAME_W-1:0] window;
  logic [CNT_W-1:0]   bit_count;

  assign ss_fall   = ss_prev & ~s_ss_n;
  assign frame_end = ~ss_prev & s_ss_n;
  assign sclk_rise = s_sclk & ~sclk_prev & ~s_ss_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_prev   <= 1'b1;
      sclk_prev <= 1'b0;
      window    <= '0;
      bit_count <= '0;
    end else begin
      ss_prev   <= s_ss_n;
      sclk_prev <= s_sclk;
      if (ss_fall) begin
        window    <= '0;
        bit_count <= '0;
      end else if (sclk_rise) begin
        window    <= {window[FRAME_W-2:0], s_mosi};
        bit_count <= bump_count(bit_count);
      end
    end
  end

  assign frame_full = (bit_count == CNT_W'(FRAME_W));
  assign frame_bits = window;

  AST_COUNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    bit_count <= CNT_W'(FRAME_W)) else $error("count past frame"); // R5
  AST_CLEAR_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    ss_fall |=> (bit_count == '0)) else $error("no clear at frame start"); // R6
  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    s_ss_n |=> $stable(window)) else $error("shift while idle"); // R7
endmodule

// File: rtl/write_issue.sv
module write_issue
  import spi_loader_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_end,
  input  logic                  frame_full,
  input  logic [FRAME_W-1:0]    frame_bits,
  output logic                  wr_en,
  output logic [REG_ADDR_W-1:0] wr_addr,
  output logic [REG_DATA_W-1:0] wr_data
);
  logic       fire;
  reg_write_t cmd;

  assign fire = frame_end & frame_full;
  assign cmd  = split_frame(frame_bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= fire;
      if (fire) begin
        wr_addr <= cmd.addr;
        wr_data <= cmd.data;
      end
    end
  end

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en) else $error("strobe too long"); // R3
  AST_STROBE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(frame_end)) else $error("strobe without frame end"); // R8
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(wr_addr) && $stable(wr_data)) else $error("fields moved"); // R7
endmodule

// File: rtl/spi_reg_loader.sv
module spi_reg_loader
  import spi_loader_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  spi_ss_n,
  input  logic                  spi_sclk,
  input  logic                  spi_mosi,
  output logic                  wr_en,
  output logic [REG_ADDR_W-1:0] wr_addr,
  output logic [REG_DATA_W-1:0] wr_data
);
  logic [2:0]         sync_out;
  logic               frame_end, frame_full;
  logic [FRAME_W-1:0] frame_bits;

  // bit 2: select (idles high), bit 1: serial clock, bit 0: data
  sync_bits #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_ss_n, spi_sclk, spi_mosi}),
    .q(sync_out)
  );

  serial_capture u_cap (
    .clk(clk), .rst_n(rst_n),
    .s_ss_n(sync_out[2]), .s_sclk(sync_out[1]), .s_mosi(sync_out[0]),
    .frame_end(frame_end), .frame_full(frame_full), .frame_bits(frame_bits)
  );

  write_issue u_wr (
    .clk(clk), .rst_n(rst_n),
    .frame_end(frame_end), .frame_full(frame_full), .frame_bits(frame_bits),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  AST_NO_STROBE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> sync_out[2]) else $error("strobe inside frame"); // R8
endmodule

// File: tb/spi_reg_loader_test.sv
module spi_reg_loader_test;
  localparam int STAGES = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ss_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic wr_en;
  logic [15:0] wr_addr, wr_data;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int fire_cycle = -100;
  logic [15:0] exp_addr = '0, exp_data = '0;
  string cur_req = "R1";
  logic sent_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_reg_loader uut (
    .clk(clk), .rst_n(rst_n), .spi_ss_n(ss_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference model compared on every clock: strobe only in the predicted cycle,
  // fields equal the model's last write at all times.
  always @(negedge clk) begin
    if (rst_n) begin
      check((cyc == fire_cycle) ? "R3" : cur_req, "wr_en", 32'(wr_en), 32'(cyc == fire_cycle));
      check(cur_req, "wr_addr", 32'(wr_addr), 32'(exp_addr));
      check(cur_req, "wr_data", 32'(wr_data), 32'(exp_data));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input string req, input int nbits, input logic [63:0] pat);
    cur_req = req;
    sent_q.delete();
    ss_n = 1'b0;
    idle(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      mosi = pat[i];
      sent_q.push_back(pat[i]);
      idle(4);
      sclk = 1'b1;
      idle(4);
      sclk = 1'b0;
    end
    idle(4);
    ss_n = 1'b1;
    if (sent_q.size() >= 32) begin
      logic [31:0] w = '0;
      for (int k = sent_q.size() - 32; k < sent_q.size(); k++) w = {w[30:0], sent_q[k]};
      fire_cycle = cyc + STAGES + 1;
      // fields follow the strobe; model them updating in the same cycle
      fork
        begin
          wait (cyc == fire_cycle);
          exp_addr = w[31:16];
          exp_data = w[15:0];
        end
      join_none
    end
    idle(10);
  endtask

  task automatic idle_clocks(input int n);
    cur_req = "R7";
    for (int i = 0; i < n; i++) begin
      mosi = i[0];
      idle(4);
      sclk = 1'b1;
      idle(4);
      sclk = 1'b0;
    end
    idle(10);
  endtask

  initial begin
    idle(3);
    check("R1", "reset wr_en", 32'(wr_en), 32'd0);
    check("R1", "reset wr_addr", 32'(wr_addr), 32'd0);
    check("R1", "reset wr_data", 32'(wr_data), 32'd0);
    rst_n = 1'b1;
    idle(5);
    send_frame("R2", 32, 64'h0000_0000_1234_ABCD);
    send_frame("R2", 32, 64'h0000_0000_8001_7FFE);
    send_frame("R4", 40, 64'h0000_00FF_C0DE_5A5A);
    send_frame("R5", 31, 64'h0000_0000_7FFF_FFFF);
    send_frame("R2", 32, 64'h0000_0000_0F0F_F0F0);
    send_frame("R6", 40, 64'h0000_0011_2233_4455);
    send_frame("R6", 31, 64'h0000_0000_1357_9BDF);
    idle_clocks(40);
    send_frame("R8", 60, 64'h0ABC_DEF0_1234_5678);
    send_frame("R5", 0, 64'h0);
    idle_clocks(5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule